// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous 1M x 4 dynamic RAM alive. It runs from a system clock of known period. After reset it first waits out the power-up settling time. It then drives a fixed number of initialization refresh cycles on its own, and only after that does it declare the memory ready. From then on a free-running interval timer produces refresh demands. These build up in a small saturating backlog and are offered to the memory controller through a request/grant handshake. Once a grant arrives, the block takes the strobes and plays one complete refresh sequence.

Two refresh styles are available, chosen per sequence by an input. The first is the internal-counter style, in which column strobe leads row strobe. The second is the row-addressed style, in which the block drives its own wrapping row counter onto the address lines and leaves column strobe high. Write enable stays high at all times, so the test-mode entry that a low write enable would trigger during an internal-counter refresh cannot happen. Every interval is given in nanoseconds and rounded up to whole clock cycles when the design is elaborated.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and for the first T_START clock edges after reset release, ras_n and cas_n are high, init_done is 0 and ref_req is 0, where T_START is the startup time rounded up to clock cycles.
- R2: Starting at the clock edge after the startup wait, exactly INIT_CYCLES refresh sequences run back to back without any grant. There is one idle cycle between sequences. init_done rises on the edge that ends the last precharge and then stays high.
- R3: In internal-counter mode (ras_only_mode = 0), cas_n is low for exactly T_SET cycles before ras_n falls and stays low until ras_n rises.
- R4: we_n is 1 in every cycle.
- R5: Every ras_n low pulse lasts exactly T_ACT = max(RAS time, CAS hold time) cycles. Between a ras_n rise and the next ras_n fall there are at least T_PRE = max(RAS precharge, CAS-to-RAS precharge) cycles.
- R6: In row-addressed mode (ras_only_mode = 1), cas_n stays high and row_addr holds steady while ras_n is low. The row counter starts at 0 after reset and advances by one at the end of each row-addressed sequence only. It wraps from 2^ROW_W-1 to 0.
- R7: ref_req is 0 until init_done. After init_done, one refresh demand is added every T_INT cycles. The first demand becomes visible T_INT edges after init_done rises. ref_req is high while the backlog is non-zero and no sequence is running.
- R8: The backlog saturates at MAX_PEND. Any further demands are dropped.
- R9: A cycle with ref_req and ref_gnt both high starts a sequence on the next edge (refresh_busy high) and removes one demand. ref_gnt while ref_req is low has no effect.
- R10: Each timing interval equals ceil(ns / CLK_NS) cycles, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only_mode | input | 1 | 1 selects row-addressed refresh for the next sequence |
| ref_gnt | input | 1 | Controller grants the strobes to the scheduler |
| ref_req | output | 1 | Refresh demand pending and sequencer idle |
| init_done | output | 1 | Power-up sequence complete |
| refresh_busy | output | 1 | Scheduler owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Refresh row for row-addressed mode |

## Verification
The bench targets the edge at which the startup wait ends and the edge at which ready rises. A design that is off by one in either counter would strobe early or raise ready a cycle late. It also fills the backlog past its limit and drains it. A non-saturating counter would wrap to zero and lose every pending refresh, and one that never stopped would let too many demands through. A grant given with no request must not consume a demand, and a design that decremented anyway would drop a refresh. The row counter is stepped through its wrap and interleaved with internal-counter sequences, which catches a counter that advances on the wrong mode or drifts while row strobe is low.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_ACT   = 2'd2,
    SQ_PRE   = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_INIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  // Round a time in ns up to whole clock cycles, never below one cycle.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_phase.sv
// Startup wait, initialization count and periodic interval timer.
module dram_ref_phase
  import dram_ref_pkg::*;
#(
  parameter int unsigned T_START     = 20000,
  parameter int unsigned T_INT       = 1560,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_done,
  input  logic seq_idle,
  output logic init_start,
  output logic tick,
  output logic ready
);

  localparam int unsigned SW = $clog2(T_START + 1);
  localparam int unsigned IW = $clog2(T_INT + 1);
  localparam int unsigned NW = $clog2(INIT_CYCLES + 1);

  phase_e        phase_q, phase_d;
  logic [SW-1:0] start_cnt_q, start_cnt_d;
  logic [IW-1:0] int_cnt_q, int_cnt_d;
  logic [NW-1:0] init_cnt_q, init_cnt_d;

  always_comb begin
    phase_d     = phase_q;
    start_cnt_d = start_cnt_q;
    int_cnt_d   = int_cnt_q;
    init_cnt_d  = init_cnt_q;
    case (phase_q)
      PH_WAIT: begin
        if (start_cnt_q == '0) phase_d = PH_INIT;
        else                   start_cnt_d = start_cnt_q - 1'b1;
      end
      PH_INIT: begin
        if (seq_done) begin
          if (init_cnt_q == NW'(INIT_CYCLES - 1)) begin
            phase_d   = PH_RUN;
            int_cnt_d = IW'(T_INT - 1);
          end else begin
            init_cnt_d = init_cnt_q + 1'b1;
          end
        end
      end
      PH_RUN: begin
        if (int_cnt_q == '0) int_cnt_d = IW'(T_INT - 1);
        else                 int_cnt_d = int_cnt_q - 1'b1;
      end
      default: phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_WAIT;
      start_cnt_q <= SW'(T_START - 1);
      int_cnt_q   <= '0;
      init_cnt_q  <= '0;
    end else begin
      phase_q     <= phase_d;
      start_cnt_q <= start_cnt_d;
      int_cnt_q   <= int_cnt_d;
      init_cnt_q  <= init_cnt_d;
    end
  end

  assign ready      = (phase_q == PH_RUN);
  assign init_start = (phase_q == PH_INIT) && seq_idle;
  assign tick       = ready && (int_cnt_q == '0);

endmodule

// File: rtl/dram_ref_backlog.sv
// Saturating count of refresh demands not yet granted.
module dram_ref_backlog #(
  parameter int unsigned MAX_PEND = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic has_pending
);

  localparam int unsigned PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (tick && !take) begin
      if (pend_q != PW'(MAX_PEND)) pend_d = pend_q + 1'b1;
    end else if (take && !tick) begin
      if (pend_q != '0) pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign has_pending = (pend_q != '0);

endmodule

// File: rtl/dram_ref_seq.sv
// Strobe sequencer for one refresh: setup, row strobe low, precharge.
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned T_SET = 1,
  parameter int unsigned T_ACT = 7,
  parameter int unsigned T_PRE = 5,
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ras_only,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] row,
  output logic             idle,
  output logic             done
);

  localparam int unsigned MAXT = umax(umax(T_SET, T_ACT), T_PRE);
  localparam int unsigned CW   = $clog2(MAXT + 1);

  seq_state_e       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             mode_q, mode_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    row_d  = row_q;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d   = SQ_SETUP;
          cnt_d  = CW'(T_SET - 1);
          mode_d = ras_only;
        end
      end
      SQ_SETUP: begin
        if (last) begin
          st_d  = SQ_ACT;
          cnt_d = CW'(T_ACT - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_ACT: begin
        if (last) begin
          st_d  = SQ_PRE;
          cnt_d = CW'(T_PRE - 1);
          if (mode_q) row_d = row_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_PRE: begin
        if (last) st_d  = SQ_IDLE;
        else      cnt_d = cnt_q - 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      row_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      row_q  <= row_d;
    end
  end

  assign idle  = (st_q == SQ_IDLE);
  assign done  = (st_q == SQ_PRE) && last;
  assign ras_n = (st_q != SQ_ACT);
  assign cas_n = !(((st_q == SQ_SETUP) || (st_q == SQ_ACT)) && !mode_q);
  assign row   = row_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned STARTUP_NS  = 200000,
  parameter int unsigned REFI_NS     = 15600,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned RAS_NS      = 70,
  parameter int unsigned CHR_NS      = 10,
  parameter int unsigned RP_NS       = 50,
  parameter int unsigned RPC_NS      = 5,
  parameter int unsigned CSR_NS      = 5,
  parameter int unsigned ROW_W       = 10,
  parameter int unsigned MAX_PEND    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_mode,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             init_done,
  output logic             refresh_busy,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);

  localparam int unsigned T_START = ns2cyc(STARTUP_NS, CLK_NS);
  localparam int unsigned T_INT   = ns2cyc(REFI_NS, CLK_NS);
  localparam int unsigned T_SET   = ns2cyc(CSR_NS, CLK_NS);
  localparam int unsigned T_ACT   = umax(ns2cyc(RAS_NS, CLK_NS), ns2cyc(CHR_NS, CLK_NS));
  localparam int unsigned T_PRE   = umax(ns2cyc(RP_NS, CLK_NS), ns2cyc(RPC_NS, CLK_NS));

  logic seq_done, seq_idle, init_start, tick, ready, has_pending, take, start;

  dram_ref_phase #(
    .T_START     (T_START),
    .T_INT       (T_INT),
    .INIT_CYCLES (INIT_CYCLES)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_done   (seq_done),
    .seq_idle   (seq_idle),
    .init_start (init_start),
    .tick       (tick),
    .ready      (ready)
  );

  dram_ref_backlog #(
    .MAX_PEND (MAX_PEND)
  ) u_backlog (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .take        (take),
    .has_pending (has_pending)
  );

  dram_ref_seq #(
    .T_SET (T_SET),
    .T_ACT (T_ACT),
    .T_PRE (T_PRE),
    .ROW_W (ROW_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ras_only (ras_only_mode),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row      (row_addr),
    .idle     (seq_idle),
    .done     (seq_done)
  );

  assign ref_req      = ready && has_pending && seq_idle;
  assign take         = ref_req && ref_gnt;
  assign start        = init_start || take;
  assign init_done    = ready;
  assign refresh_busy = !seq_idle;
  assign we_n         = 1'b1;

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int unsigned T_ACT = 7,
  parameter int unsigned T_PRE = 5,
  parameter int unsigned ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             init_done,
  input logic             ref_req,
  input logic             ref_gnt,
  input logic             refresh_busy
);

  logic [15:0] low_cnt, high_cnt;
  logic        seen_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      high_cnt  <= '0;
      seen_rise <= 1'b0;
    end else begin
      low_cnt  <= ras_n ? 16'd0 : low_cnt + 16'd1;
      high_cnt <= ras_n ? high_cnt + 16'd1 : 16'd0;
      if (ras_n && (low_cnt != 16'd0)) seen_rise <= 1'b1;
    end
  end

  AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req); // R7
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_done) |-> init_done); // R2
  AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0)); // R3
  AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n) && !$past(cas_n)) |-> !cas_n); // R3
  AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n)) |-> $stable(row_addr)); // R6
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && (low_cnt != 16'd0)) |-> (low_cnt == 16'(T_ACT))); // R5
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && (high_cnt != 16'd0) && seen_rise) |-> (high_cnt >= 16'(T_PRE))); // R5
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (ras_n && cas_n && !refresh_busy)); // R9
  AST_GNT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> refresh_busy); // R9

endmodule

bind dram_refresh_sched dram_refresh_chk #(
  .T_ACT (T_ACT),
  .T_PRE (T_PRE),
  .ROW_W (ROW_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .row_addr     (row_addr),
  .init_done    (init_done),
  .ref_req      (ref_req),
  .ref_gnt      (ref_gnt),
  .refresh_busy (refresh_busy)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;

  localparam int CLK     = 10;
  localparam int ST_NS   = 195;
  localparam int RI_NS   = 395;
  localparam int INIT_N  = 8;
  localparam int RAS_NS  = 25;
  localparam int CHR_NS  = 10;
  localparam int RP_NS   = 15;
  localparam int RPC_NS  = 5;
  localparam int CSR_NS  = 15;
  localparam int RW      = 4;
  localparam int MAXP    = 3;

  localparam int T_START = (ST_NS + CLK - 1) / CLK;   // 20
  localparam int T_INT   = (RI_NS + CLK - 1) / CLK;   // 40
  localparam int T_SET   = (CSR_NS + CLK - 1) / CLK;  // 2
  localparam int T_ACT   = 3;                          // max(ceil 2.5, ceil 1)
  localparam int T_PRE   = 2;                          // max(ceil 1.5, ceil 0.5)
  localparam int SEQ_L   = T_SET + T_ACT + T_PRE;
  localparam int R_EDGE  = T_START + INIT_N * (SEQ_L + 1);
  localparam int ROWS    = 1 << RW;

  logic clk = 1'b0;
  logic rst_n, mode, ref_gnt;
  logic ref_req, init_done, refresh_busy, ras_n, cas_n, we_n;
  logic [RW-1:0] row_addr;

  always #(CLK/2) clk = ~clk;

  dram_refresh_sched #(
    .CLK_NS(CLK), .STARTUP_NS(ST_NS), .REFI_NS(RI_NS), .INIT_CYCLES(INIT_N),
    .RAS_NS(RAS_NS), .CHR_NS(CHR_NS), .RP_NS(RP_NS), .RPC_NS(RPC_NS),
    .CSR_NS(CSR_NS), .ROW_W(RW), .MAX_PEND(MAXP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ras_only_mode(mode), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .init_done(init_done), .refresh_busy(refresh_busy),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
  );

  int  n_vec = 0, n_bad = 0;
  int  cyc = 0;
  bit  finished = 0;
  int  seqs = 0, we_bad = 0, low_len = 0, high_len = 0, cas_lead = 0;
  int  exp_row = 0;
  bit  prev_ras = 1, seen_rise = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Strobe monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      if (we_n !== 1'b1) we_bad++;
      if (!ras_n) begin
        if (prev_ras) begin
          if (!mode) chk(cas_lead == T_SET, "R3 R10 cas lead", cas_lead, T_SET);
          else       chk(row_addr == RW'(exp_row), "R6 row at fall", row_addr, exp_row);
          if (seen_rise) chk(high_len >= T_PRE, "R5 precharge", high_len, T_PRE);
        end
        if (!mode) chk(cas_n == 1'b0, "R3 cas held low", cas_n, 0);
        else       chk(cas_n == 1'b1 && row_addr == RW'(exp_row), "R6 cas high row steady", row_addr, exp_row);
        low_len++;
      end else begin
        if (!prev_ras) begin
          chk(low_len == T_ACT, "R5 ras width", low_len, T_ACT);
          seqs++;
          seen_rise = 1;
          if (mode) exp_row = (exp_row + 1) % ROWS;
          high_len = 0;
          low_len = 0;
        end
        high_len++;
        cas_lead = cas_n ? 0 : cas_lead + 1;
      end
      prev_ras = ras_n;
    end
  end

  task automatic drain(output int n);
    n = 0;
    while (ref_req && n < 10) begin
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
      chk(refresh_busy == 1'b1, "R9 grant starts sequence", refresh_busy, 1);
      repeat (SEQ_L) @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; mode = 1'b0; ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && !init_done && !ref_req, "R1 reset state",
        {ras_n, cas_n, we_n, init_done, ref_req}, 5'b11100);
    rst_n = 1'b1;
    while (cyc < T_START) begin
      @(negedge clk);
      chk(ras_n && cas_n && !init_done && !ref_req, "R1 R10 startup quiet", cyc, T_START);
    end
    @(negedge clk);
    chk(cas_n == 1'b0 && ras_n == 1'b1, "R2 first init strobe", cas_n, 0);
    while (!init_done) begin
      chk(!ref_req, "R7 no request before ready", ref_req, 0);
      @(negedge clk);
    end
    chk(cyc == R_EDGE, "R2 ready edge", cyc, R_EDGE);
    chk(seqs == INIT_N, "R2 init sequence count", seqs, INIT_N);
    while (!ref_req) @(negedge clk);
    chk(cyc == R_EDGE + T_INT, "R7 first demand", cyc, R_EDGE + T_INT);

    // fill past the limit, then drain right after a tick
    while (cyc != R_EDGE + 6 * T_INT) @(negedge clk);
    drain(n);
    chk(n == MAXP, "R8 backlog saturates", n, MAXP);
    chk(!ref_req, "R8 empty after drain", ref_req, 0);

    // stray grant
    ref_gnt = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(ras_n && cas_n && !refresh_busy, "R9 grant without request ignored", refresh_busy, 0);
    end
    ref_gnt = 1'b0;
    while (cyc != R_EDGE + 7 * T_INT) @(negedge clk);
    chk(ref_req, "R7 periodic demand", ref_req, 1);
    drain(n);
    chk(n == 1, "R9 stray grant took nothing", n, 1);

    // row-addressed sweep through the wrap
    mode = 1'b1;
    for (int i = 0; i < ROWS + 4; i++) begin
      while (!ref_req) @(negedge clk);
      drain(n);
    end
    chk(exp_row == (ROWS + 4) % ROWS, "R6 row wrap", exp_row, (ROWS + 4) % ROWS);
    chk(row_addr == RW'((ROWS + 4) % ROWS), "R6 row counter value", row_addr, (ROWS + 4) % ROWS);

    // internal-counter sequence must not move the row
    mode = 1'b0;
    while (!ref_req) @(negedge clk);
    drain(n);
    chk(row_addr == RW'((ROWS + 4) % ROWS), "R6 row unchanged by CBR", row_addr, (ROWS + 4) % ROWS);
    mode = 1'b1;
    while (!ref_req) @(negedge clk);
    drain(n);
    chk(row_addr == RW'((ROWS + 5) % ROWS), "R6 row resumes", row_addr, (ROWS + 5) % ROWS);

    chk(we_bad == 0, "R4 we_n never low", we_bad, 0);
    chk(init_done, "R2 ready held", init_done, 1);
    finish_run();
  end

endmodule